// File: doc/BRIEF.md
# DRAM Refresh Sequencer with Power-Up Initialization

This block keeps a 256-row asynchronous DRAM refreshed. It derives a refresh interval from the system clock. The clock period is a parameter, given in picoseconds. When an interval ends, the block requests the memory bus from the access controller. Once the controller grants the bus, the block drives a refresh cycle of the CAS-before-RAS kind directly on the row and column strobes. The memory's internal row counter picks the row, so the block has no address output. While the block owns the bus, the write strobes stay inactive and the data-drive enable stays low.

After reset the block first holds the strobes idle for a long power-up pause. It then runs a burst of refresh cycles on its own, without asking for a grant, because no other master is allowed on the bus yet. Only after that burst does it raise `ready`. Until `ready` is high, the permission output for normal accesses (`host_ok`) stays low.

Interval expirations that arrive while the grant is withheld are counted in a small saturating counter. When the grant arrives, all counted refreshes run back to back under one bus ownership. The access controller is expected to hand over the bus with both strobes already precharged. After each cycle the block returns the bus with a full precharge already elapsed.

Top module: `dram_refresh_seq`

## Requirements
- R1: Once `ready` is high and the grant is answered promptly, one refresh cycle is issued per `T_REF_INT_NS`. The interval is rounded down to whole clocks (780 clocks at the defaults), so that it never exceeds the interval.
- R2: In reset, `ras_n` and `cas_n` are high and `ready`, `rfs_req`, `bus_own` and `host_ok` are low. After reset is released, `cas_n` stays high for at least `T_PAUSE_NS` (5000 clocks at the defaults).
- R3: After the pause, exactly `INIT_CYCLES` refresh cycles run without a grant. `ready` rises after the last of them and stays high until the next reset.
- R4: In every refresh cycle, `cas_n` is already low at least `T_CSR_NS` before `ras_n` falls. It stays low at least `T_CHR_NS` after `ras_n` falls.
- R5: `ras_n` stays low at least `T_RAS_NS` and stays high at least `T_RP_NS` between cycles. Successive falls of `ras_n` are at least `T_RC_NS` apart. `cas_n` stays high at least `T_CPN_NS` between cycles.
- R6: Both write strobes `we_n` stay high and `dq_oe` stays low at all times.
- R7: Expirations that occur while the grant is withheld are counted. When the grant comes, they are issued back to back with `bus_own` held high throughout. While requesting but not owning the bus, `rfs_req` is not withdrawn.
- R8: The backlog saturates at `PEND_MAX` (4 at the defaults). Further expirations are then dropped, and the next normal interval is unaffected.
- R9: After `ready`, a refresh cycle starts only in the clock after `rfs_gnt` was seen high. While `bus_own` is low, `ras_n` and `cas_n` are both high.
- R10: `host_ok` is high exactly when `ready` is high and `rfs_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rfs_gnt | input | 1 | Bus grant from the access controller |
| rfs_req | output | 1 | Bus request for refresh |
| bus_own | output | 1 | Block is driving the memory strobes |
| host_ok | output | 1 | Normal accesses may be started |
| ready | output | 1 | Power-up pause and initial burst are complete |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 2 | Upper and lower byte write strobes, active low |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
The assertions check on every cycle:
- the order of the column strobe against the row strobe at each row fall;
- the minimum row-low width;
- that the strobes are idle whenever the bus is not owned;
- that a cycle is started only after a grant;
- that `ready` never drops;
- that a pending request is held until it is served.

Other behaviours only show over whole scenarios, so the bench covers them:
- the exact number of refreshes per interval window;
- the length of the power-up pause and the count of the initial burst;
- the backlog of three refreshes served under a single ownership;
- saturation after seven missed intervals.

The bench also runs a phase with random grant latency and checks that no interval is lost.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE = 3'd0,
    ST_IDLE  = 3'd1,
    ST_LEAD  = 3'd2,
    ST_ACT   = 3'd3,
    ST_PRE   = 3'd4
  } rfs_state_e;

  // Round a time in ns up to whole clocks of clk_ps picoseconds.
  function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                            input int unsigned clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned max2(input int unsigned a,
                                       input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rfs_tick_gen.sv
module rfs_tick_gen #(
  parameter int unsigned N_INT = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned W = (N_INT > 1) ? $clog2(N_INT) : 1;
  localparam logic [W-1:0] LAST = W'(N_INT - 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!en)               cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                   cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = en && (cnt_q == LAST);
endmodule

// File: rtl/rfs_pend_ctr.sv
module rfs_pend_ctr #(
  parameter int unsigned PEND_MAX = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic pend_nz
);
  localparam int unsigned PW = $clog2(PEND_MAX + 1);
  localparam logic [PW-1:0] TOP = PW'(PEND_MAX);

  logic [PW-1:0] pend_q, pend_d;
  logic          pend_en;

  always_comb begin
    pend_d  = pend_q;
    pend_en = 1'b0;
    unique case ({inc, dec})
      2'b10: if (pend_q != TOP) begin
        pend_d  = pend_q + PW'(1);
        pend_en = 1'b1;
      end
      2'b01: if (pend_q != '0) begin
        pend_d  = pend_q - PW'(1);
        pend_en = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend_nz = (pend_q != '0);
endmodule

// File: rtl/rfs_cycle_fsm.sv
module rfs_cycle_fsm
  import rfs_pkg::*;
#(
  parameter int unsigned N_PAUSE     = 5000,
  parameter int unsigned N_CSR       = 1,
  parameter int unsigned N_CHR       = 1,
  parameter int unsigned N_RAS       = 4,
  parameter int unsigned N_PRE       = 3,
  parameter int unsigned INIT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pend_nz,
  input  logic gnt,
  output logic ras_n,
  output logic cas_n,
  output logic busy,
  output logic ready,
  output logic take
);
  localparam int unsigned CMAX = max2(max2(N_PAUSE, N_RAS), max2(N_PRE, N_CSR));
  localparam int unsigned CW   = $clog2(CMAX + 1);
  localparam int unsigned IW   = $clog2(INIT_CYCLES + 1);
  localparam logic [CW-1:0] C_PAUSE = CW'(N_PAUSE - 1);
  localparam logic [CW-1:0] C_CSR   = CW'(N_CSR - 1);
  localparam logic [CW-1:0] C_RAS   = CW'(N_RAS - 1);
  localparam logic [CW-1:0] C_PRE   = CW'(N_PRE - 1);
  localparam logic [CW-1:0] C_CHR   = CW'(N_CHR);

  rfs_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] init_q, init_d;
  logic          rdy_q, rdy_d;
  logic          ras_d, cas_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q + CW'(1);
    init_d = init_q;
    rdy_d  = rdy_q;
    take   = 1'b0;
    unique case (st_q)
      ST_PAUSE: if (cnt_q == C_PAUSE) begin
        st_d   = ST_LEAD;
        cnt_d  = '0;
        init_d = init_q - IW'(1);
      end
      ST_IDLE: begin
        cnt_d = '0;
        if (pend_nz && gnt) begin
          st_d = ST_LEAD;
          take = 1'b1;
        end
      end
      ST_LEAD: if (cnt_q == C_CSR) begin
        st_d  = ST_ACT;
        cnt_d = '0;
      end
      ST_ACT: if (cnt_q == C_RAS) begin
        st_d  = ST_PRE;
        cnt_d = '0;
      end
      ST_PRE: if (cnt_q == C_PRE) begin
        cnt_d = '0;
        if (!rdy_q) begin
          if (init_q != '0) begin
            st_d   = ST_LEAD;
            init_d = init_q - IW'(1);
          end else begin
            st_d  = ST_IDLE;
            rdy_d = 1'b1;
          end
        end else if (pend_nz) begin
          st_d = ST_LEAD;
          take = 1'b1;
        end else begin
          st_d = ST_IDLE;
        end
      end
      default: begin
        st_d  = ST_IDLE;
        cnt_d = '0;
      end
    endcase
    ras_d = (st_d != ST_ACT);
    cas_d = !((st_d == ST_LEAD) || ((st_d == ST_ACT) && (cnt_d < C_CHR)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_PAUSE;
      cnt_q  <= '0;
      init_q <= IW'(INIT_CYCLES);
      rdy_q  <= 1'b0;
      ras_n  <= 1'b1;
      cas_n  <= 1'b1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      init_q <= init_d;
      rdy_q  <= rdy_d;
      ras_n  <= ras_d;
      cas_n  <= cas_d;
    end
  end

  assign busy  = (st_q == ST_LEAD) || (st_q == ST_ACT) || (st_q == ST_PRE);
  assign ready = rdy_q;
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import rfs_pkg::*;
#(
  parameter int unsigned CLK_PS       = 20000,
  parameter int unsigned T_REF_INT_NS = 15600,
  parameter int unsigned T_PAUSE_NS   = 100000,
  parameter int unsigned T_CSR_NS     = 10,
  parameter int unsigned T_CHR_NS     = 10,
  parameter int unsigned T_RPC_NS     = 10,
  parameter int unsigned T_CPN_NS     = 10,
  parameter int unsigned T_RAS_NS     = 80,
  parameter int unsigned T_RP_NS      = 60,
  parameter int unsigned T_RC_NS      = 145,
  parameter int unsigned INIT_CYCLES  = 8,
  parameter int unsigned PEND_MAX     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rfs_gnt,
  output logic       rfs_req,
  output logic       bus_own,
  output logic       host_ok,
  output logic       ready,
  output logic       ras_n,
  output logic       cas_n,
  output logic [1:0] we_n,
  output logic       dq_oe
);
  localparam int unsigned N_CSR   = max2(ns_to_cyc(T_CSR_NS, CLK_PS), 1);
  localparam int unsigned N_CHR   = max2(ns_to_cyc(T_CHR_NS, CLK_PS), 1);
  localparam int unsigned N_RAS   = max2(ns_to_cyc(T_RAS_NS, CLK_PS), N_CHR + 1);
  localparam int unsigned N_RC    = ns_to_cyc(T_RC_NS, CLK_PS);
  localparam int unsigned N_RCTL  = (N_RC > N_RAS + N_CSR) ? N_RC - N_RAS - N_CSR : 1;
  localparam int unsigned N_PRE   = max2(max2(ns_to_cyc(T_RP_NS, CLK_PS),
                                              ns_to_cyc(T_RPC_NS, CLK_PS)),
                                         max2(ns_to_cyc(T_CPN_NS, CLK_PS), N_RCTL));
  localparam int unsigned N_PAUSE = max2(ns_to_cyc(T_PAUSE_NS, CLK_PS), 1);
  localparam int unsigned N_INT   = max2((T_REF_INT_NS * 1000) / CLK_PS, 2);

  logic tick, take, pend_nz, busy, rdy;

  rfs_tick_gen #(.N_INT(N_INT)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(rdy), .tick(tick)
  );

  rfs_pend_ctr #(.PEND_MAX(PEND_MAX)) u_pend (
    .clk(clk), .rst_n(rst_n), .inc(tick), .dec(take), .pend_nz(pend_nz)
  );

  rfs_cycle_fsm #(
    .N_PAUSE(N_PAUSE), .N_CSR(N_CSR), .N_CHR(N_CHR),
    .N_RAS(N_RAS), .N_PRE(N_PRE), .INIT_CYCLES(INIT_CYCLES)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .pend_nz(pend_nz), .gnt(rfs_gnt),
    .ras_n(ras_n), .cas_n(cas_n), .busy(busy), .ready(rdy), .take(take)
  );

  assign ready   = rdy;
  assign bus_own = busy;
  assign rfs_req = rdy && (pend_nz || busy);
  assign host_ok = rdy && !rfs_req;
  assign we_n    = 2'b11;
  assign dq_oe   = 1'b0;
endmodule

// File: rtl/rfs_seq_chk.sv
module rfs_seq_chk #(
  parameter int unsigned CLK_PS   = 20000,
  parameter int unsigned T_RAS_NS = 80
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic bus_own,
  input logic rfs_req,
  input logic rfs_gnt,
  input logic ready,
  input logic host_ok
);
  localparam int unsigned RAS_MIN = (T_RAS_NS * 1000 + CLK_PS - 1) / CLK_PS;

  logic [15:0] ras_lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ras_lo_q <= '0;
    else if (!ras_n) ras_lo_q <= ras_lo_q + 16'd1;
    else             ras_lo_q <= '0;
  end

  // R4: column strobe low in this and the previous cycle at row fall
  p_cbr_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && ($past(cas_n) == 1'b0)));

  // R4: column strobe rises only after row strobe has been low a cycle
  p_cbr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cas_n) && !ras_n) |-> ($past(ras_n) == 1'b0));

  // R5: row strobe low width
  p_ras_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (ras_lo_q >= 16'(RAS_MIN)));

  // R3: ready is sticky
  p_ready_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  // R9: strobes idle when bus not owned
  p_idle_pins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_own |-> (ras_n && cas_n));

  // R9: a fresh ownership after ready follows a grant
  p_gnt_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $rose(bus_own)) |-> ($past(rfs_gnt) == 1'b1));

  // R7: a waiting request is not withdrawn
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rfs_req && !bus_own) |=> rfs_req);

  // R10: no normal access before ready or during refresh ownership
  p_host_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready || bus_own) |-> !host_ok);
endmodule

bind dram_refresh_seq rfs_seq_chk #(.CLK_PS(CLK_PS), .T_RAS_NS(T_RAS_NS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .bus_own(bus_own),
  .rfs_req(rfs_req), .rfs_gnt(rfs_gnt), .ready(ready), .host_ok(host_ok)
);

// File: tb/sim_dram_refresh_seq.sv
`timescale 1ns/1ps
module sim_dram_refresh_seq;
  localparam int unsigned PS = 20000;

  function automatic longint cyc_up(input longint ns);
    return (ns * 1000 + PS - 1) / PS;
  endfunction

  localparam longint E_CSR   = 1;
  localparam longint E_INT   = (15600 * 1000) / PS;

  logic clk = 1'b0;
  logic rst_n;
  logic rfs_gnt;
  logic rfs_req, bus_own, host_ok, ready, ras_n, cas_n, dq_oe;
  logic [1:0] we_n;

  always #10 clk = ~clk;

  dram_refresh_seq u0 (
    .clk(clk), .rst_n(rst_n), .rfs_gnt(rfs_gnt), .rfs_req(rfs_req),
    .bus_own(bus_own), .host_ok(host_ok), .ready(ready), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .dq_oe(dq_oe)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor state
  longint rel_t = -1, rdy_t = -1;
  longint ras_fall_t = -1, ras_rise_t = -1, cas_fall_t = -1, cas_rise_t = -1;
  longint first_cas_t = -1;
  int nref = 0, nburst = 0, own_rises = 0;
  int bad6 = 0, bad9 = 0, bad10 = 0, bad3 = 0;
  logic p_ras = 1'b1, p_cas = 1'b1, p_own = 1'b0, p_rdy = 1'b0, p_gnt = 1'b0;

  always @(negedge clk) begin
    if (rst_n && rel_t >= 0) begin
      if (we_n !== 2'b11 || dq_oe !== 1'b0) bad6++;
      if (!bus_own && (ras_n !== 1'b1 || cas_n !== 1'b1)) bad9++;
      if (host_ok !== (ready && !rfs_req)) bad10++;
      if (p_rdy && !ready) bad3++;
      if (ras_n !== p_ras) begin
        if (!ras_n) begin
          chk(!cas_n, "R4 cas low at ras fall", cas_n, 0);
          chk(cyc - cas_fall_t >= E_CSR, "R4 cas lead", cyc - cas_fall_t, E_CSR);
          if (ras_rise_t >= 0)
            chk(cyc - ras_rise_t >= cyc_up(60), "R5 ras precharge",
                cyc - ras_rise_t, cyc_up(60));
          if (ras_fall_t >= 0)
            chk(cyc - ras_fall_t >= cyc_up(145), "R5 cycle time",
                cyc - ras_fall_t, cyc_up(145));
          ras_fall_t = cyc;
          nref++;
          if (!ready) nburst++;
        end else begin
          chk(cyc - ras_fall_t >= cyc_up(80), "R5 ras low width",
              cyc - ras_fall_t, cyc_up(80));
          ras_rise_t = cyc;
        end
      end
      if (cas_n !== p_cas) begin
        if (!cas_n) begin
          if (first_cas_t < 0) begin
            first_cas_t = cyc;
            chk(cyc - rel_t >= cyc_up(100000), "R2 power-up pause",
                cyc - rel_t, cyc_up(100000));
          end
          if (cas_rise_t >= 0)
            chk(cyc - cas_rise_t >= cyc_up(10), "R5 cas high between",
                cyc - cas_rise_t, cyc_up(10));
          if (ready && !p_own)
            chk(p_gnt, "R9 start after grant", p_gnt, 1);
          cas_fall_t = cyc;
        end else begin
          if (!ras_n)
            chk(cyc - ras_fall_t >= cyc_up(10), "R4 cas hold",
                cyc - ras_fall_t, cyc_up(10));
          cas_rise_t = cyc;
        end
      end
      if (ready && !p_rdy) begin
        rdy_t = cyc;
        chk(nburst == 8, "R3 initial burst count", nburst, 8);
      end
      if (bus_own && !p_own) own_rises++;
      p_ras = ras_n; p_cas = cas_n; p_own = bus_own; p_rdy = ready; p_gnt = rfs_gnt;
    end
  end

  // Bus controller model
  bit hold = 1'b0, rand_mode = 1'b0;
  int lat = 0;
  task automatic ctl_step();
    if (!rfs_req) begin
      rfs_gnt = 1'b0;
      lat = rand_mode ? int'($urandom_range(0, 200)) : 0;
    end else if (hold) begin
      rfs_gnt = 1'b0;
    end else if (lat > 0) begin
      lat--;
    end else begin
      rfs_gnt = 1'b1;
    end
  endtask

  task automatic wait_until(input longint t);
    while (cyc < t) @(negedge clk);
  endtask

  initial begin
    longint base;
    int n0, o0;
    void'($urandom(32'd7331));
    rst_n = 1'b0;
    rfs_gnt = 1'b0;
    fork
      forever begin @(negedge clk); if (rst_n) ctl_step(); end
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          n_fail++;
          $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
          $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
          $finish;
        end
      end
    join_none

    repeat (4) @(negedge clk);
    // R2: reset state
    chk(ras_n === 1'b1 && cas_n === 1'b1, "R2 reset strobes", {ras_n, cas_n}, 3);
    chk({ready, rfs_req, bus_own, host_ok} === 4'b0, "R2 reset outputs",
        {ready, rfs_req, bus_own, host_ok}, 0);
    rst_n = 1'b1;
    rel_t = cyc;

    while (!ready) @(negedge clk);
    @(negedge clk);
    base = rdy_t;

    // R1: ten intervals with prompt grant
    wait_until(base + 10 * E_INT + 50);
    chk(nref - 8 == 10, "R1 refreshes per window", nref - 8, 10);

    // Random grant latency, no interval lost
    rand_mode = 1'b1;
    wait_until(base + 30 * E_INT + 250);
    chk(nref - 8 == 30, "R1 random latency count", nref - 8, 30);
    rand_mode = 1'b0;

    // R7: backlog of three
    wait_until(base + 30 * E_INT + 300);
    hold = 1'b1;
    n0 = nref;
    wait_until(base + 33 * E_INT + 300);
    chk(nref - n0 == 0, "R9 no cycle while grant withheld", nref - n0, 0);
    chk(rfs_req === 1'b1, "R7 request held", rfs_req, 1);
    o0 = own_rises;
    hold = 1'b0;
    wait_until(base + 33 * E_INT + 450);
    chk(nref - n0 == 3, "R7 backlog served", nref - n0, 3);
    chk(own_rises - o0 == 1, "R7 single ownership", own_rises - o0, 1);

    // R8: saturation
    hold = 1'b1;
    n0 = nref;
    wait_until(base + 40 * E_INT + 300);
    hold = 1'b0;
    wait_until(base + 40 * E_INT + 450);
    chk(nref - n0 == 4, "R8 saturated backlog", nref - n0, 4);
    n0 = nref;
    wait_until(base + 41 * E_INT + 300);
    chk(nref - n0 == 1, "R8 next interval normal", nref - n0, 1);

    chk(bad6 == 0, "R6 write strobes and data enable", bad6, 0);
    chk(bad9 == 0, "R9 strobes idle when not owned", bad9, 0);
    chk(bad10 == 0, "R10 host permission", bad10, 0);
    chk(bad3 == 0, "R3 ready sticky", bad3, 0);
    chk(host_ok === 1'b1, "R10 host permitted when idle", host_ok, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule